// File: doc/BRIEF.md
# Folded Second-Order Recursive Filter

This block implements a second-order recursive filter section with a single delay line in the canonic direct form. All of its arithmetic shares one saturating adder and one two-stage constant multiplier. A two-bit step counter repeats a fixed four-cycle schedule. In each period the multiplier starts four coefficient products and the adder performs four additions. Values that are consumed in the same cycle they are produced go over direct paths. Values that must wait are kept in two small register files. Each register file has one write port and one read port. The first is written by the adder and holds the filter state. The second is written by the multiplier and holds one waiting product.

Samples are 16-bit two's complement values and the coefficients are Q1.15 constants. The state follows w[n] = x[n] + 0.2·w[n-1] + 0.4·w[n-2]. The output follows y[n] = w[n] + 0.3·w[n-1] + 0.6·w[n-2]. The feedback pair is summed before the input is added. The feedforward pair is summed on its own before it is added to w[n]. One output pin, `strobe_o`, serves both directions. In the cycle it is high, the block takes `x_i` and shows a fresh `y_o`.

Top module: `folded_biquad`

## Requirements
- R1: While reset is active, and after reset until the first strobe, `y_o` is 0. After reset is released, `strobe_o` first goes high in the fourth cycle, that is, after three rising edges.
- R2: `strobe_o` is high in exactly one cycle of every four, and never in two consecutive cycles.
- R3: `y_o` changes only in a cycle where `strobe_o` is high. It holds its value through the other three cycles of the period.
- R4: `x_i` is sampled only in a cycle where `strobe_o` is high. Its value in any other cycle has no effect on later outputs.
- R5: Every coefficient product is rounded to DATA_W bits as (v·c + 2^14) >>> 15, using an arithmetic shift, and saturated to the 16-bit range. Its magnitude never exceeds the magnitude of the sample operand.
- R6: The state recursion is w[n] = sat(x[n] + sat(p(0.2,w[n-1]) + p(0.4,w[n-2]))). Here p is the rounded product of R5 and sat clamps to [-32768, 32767]. The coefficients are 6554 and 13107.
- R7: The output is y[n] = sat(w[n] + sat(p(0.3,w[n-1]) + p(0.6,w[n-2]))), with coefficients 9830 and 19661. y[n] appears on `y_o` at the strobe that follows the strobe that sampled x[n].
- R8: Every addition saturates. Sustained full-scale input drives `y_o` to 32767 for positive input and to -32768 for negative input, with no wrap.
- R9: A reset asserted in the middle of a stream clears both stored states. The response that follows matches the response from a cold start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| x_i | input | 16 | Input sample, two's complement, taken while strobe_o is high |
| y_o | output | 16 | Output sample, two's complement, refreshed when strobe_o is high |
| strobe_o | output | 1 | High for one cycle every four; marks the input sample and the output update |

## Verification
The output register is loaded at the third step of a period. The new value is therefore visible in the strobe cycle, one period after the sample was taken, so each y[n] is compared at the strobe that follows the one that took x[n]. The bench drives and samples on the falling edge. It checks `y_o` at every strobe against a bit-exact model of R6 and R7. In each of the three quiet cycles of a period it checks that `y_o` has not moved, and it drives unrelated values on `x_i` at the same time. After every reset it counts falling edges to confirm that the first strobe arrives exactly on the third one.

// File: rtl/folded_biquad_pkg.sv
package folded_biquad_pkg;

  typedef enum logic [1:0] {
    STEP_0 = 2'd0,
    STEP_1 = 2'd1,
    STEP_2 = 2'd2,
    STEP_3 = 2'd3
  } step_e;

  // adder operand pairing per step
  typedef enum logic [1:0] {
    ADD_PRD_MUL = 2'd0, // stored product + fresh product
    ADD_ST_ACC  = 2'd1, // stored state + accumulator
    ADD_MUL_PRD = 2'd2, // fresh product + stored product
    ADD_IN_ACC  = 2'd3  // input sample + accumulator
  } add_mode_e;

  typedef enum logic [1:0] {
    CF_A1 = 2'd0,
    CF_A2 = 2'd1,
    CF_B1 = 2'd2,
    CF_B2 = 2'd3
  } coef_e;

endpackage

// File: rtl/fb_regfile.sv
module fb_regfile #(
  parameter int W     = 16,
  parameter int DEPTH = 2,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [AW-1:0]       waddr_i,
  input  logic signed [W-1:0] wdata_i,
  input  logic [AW-1:0]       raddr_i,
  output logic signed [W-1:0] rdata_o
);

  logic signed [W-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           mem_q[g] <= '0;
      else if (we_i && waddr_i == AW'(g))   mem_q[g] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < DEPTH; i++)
      if (raddr_i == AW'(i)) rdata_o = mem_q[i];
  end

endmodule

// File: rtl/fb_ctrl.sv
module fb_ctrl
  import folded_biquad_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  output logic      strobe_o,
  output logic      mul_from_acc_o,
  output coef_e     coef_sel_o,
  output add_mode_e add_mode_o,
  output logic      m0_we_o,
  output logic      m0_waddr_o,
  output logic      m0_raddr_o,
  output logic      m1_we_o,
  output logic      y_load_o
);

  step_e step_q;
  logic  par_q; // which state slot holds the newest w

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= STEP_0;
      par_q  <= 1'b0;
    end else begin
      step_q <= step_e'(step_q + 2'd1);
      if (step_q == STEP_3) par_q <= ~par_q;
    end
  end

  always_comb begin
    strobe_o       = 1'b0;
    mul_from_acc_o = 1'b0;
    coef_sel_o     = CF_A1;
    add_mode_o     = ADD_PRD_MUL;
    m0_we_o        = 1'b0;
    m0_waddr_o     = par_q;
    m0_raddr_o     = par_q;
    m1_we_o        = 1'b0;
    y_load_o       = 1'b0;
    unique case (step_q)
      STEP_0: begin // new w on accumulator: store it, scale by a1
        mul_from_acc_o = 1'b1;
        coef_sel_o     = CF_A1;
        add_mode_o     = ADD_PRD_MUL;
        m0_we_o        = 1'b1;
      end
      STEP_1: begin // one read of w[n] feeds both units
        coef_sel_o = CF_B1;
        add_mode_o = ADD_ST_ACC;
        m1_we_o    = 1'b1;
      end
      STEP_2: begin
        coef_sel_o = CF_B2;
        add_mode_o = ADD_MUL_PRD;
        m0_raddr_o = ~par_q;
        y_load_o   = 1'b1;
      end
      STEP_3: begin
        coef_sel_o = CF_A2;
        add_mode_o = ADD_IN_ACC;
        m1_we_o    = 1'b1;
        strobe_o   = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/fb_cmul.sv
module fb_cmul #(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  parameter int FRAC_W = 15,
  localparam int PW    = DATA_W + COEF_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic signed [DATA_W-1:0] a_i,
  input  logic signed [COEF_W-1:0] c_i,
  output logic signed [DATA_W-1:0] p_o
);

  localparam logic signed [PW:0] HALF = (PW+1)'(1) <<< (FRAC_W - 1);

  logic signed [PW-1:0]     prod_q;
  logic signed [PW:0]       rnd;
  logic signed [PW:0]       shf;
  logic signed [DATA_W-1:0] sat;

  always_comb begin
    rnd = (PW+1)'(prod_q) + HALF;
    shf = rnd >>> FRAC_W;
    if ((&shf[PW:DATA_W-1]) || !(|shf[PW:DATA_W-1])) sat = shf[DATA_W-1:0];
    else if (shf[PW])                                 sat = {1'b1, {(DATA_W-1){1'b0}}};
    else                                              sat = {1'b0, {(DATA_W-1){1'b1}}};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prod_q <= '0;
      p_o    <= '0;
    end else begin
      prod_q <= PW'(a_i) * PW'(c_i);
      p_o    <= sat;
    end
  end

endmodule

// File: rtl/fb_sat_add.sv
module fb_sat_add #(
  parameter int DATA_W = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic signed [DATA_W-1:0] a_i,
  input  logic signed [DATA_W-1:0] b_i,
  output logic signed [DATA_W-1:0] s_o
);

  logic signed [DATA_W:0]   sum;
  logic signed [DATA_W-1:0] sat;

  always_comb begin
    sum = (DATA_W+1)'(a_i) + (DATA_W+1)'(b_i);
    if (sum[DATA_W] == sum[DATA_W-1]) sat = sum[DATA_W-1:0];
    else if (sum[DATA_W])             sat = {1'b1, {(DATA_W-1){1'b0}}};
    else                              sat = {1'b0, {(DATA_W-1){1'b1}}};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) s_o <= '0;
    else         s_o <= sat;
  end

endmodule

// File: rtl/folded_biquad.sv
module folded_biquad
  import folded_biquad_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int COEF_W  = 16,
  parameter int FRAC_W  = 15,
  parameter int COEF_A1 = 6554,
  parameter int COEF_A2 = 13107,
  parameter int COEF_B1 = 9830,
  parameter int COEF_B2 = 19661
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic signed [DATA_W-1:0] x_i,
  output logic signed [DATA_W-1:0] y_o,
  output logic                     strobe_o
);

  localparam int ST_DEPTH  = 2; // w[n] and w[n-1]
  localparam int PRD_DEPTH = 1; // the two waiting products never overlap

  logic      mul_from_acc, m0_we, m0_waddr, m0_raddr, m1_we, y_load;
  coef_e     coef_sel;
  add_mode_e add_mode;

  logic signed [DATA_W-1:0] acc_q, mul_q, st_rd, prd_rd;
  logic signed [DATA_W-1:0] mul_a, add_a, add_b;
  logic signed [COEF_W-1:0] mul_c;

  fb_ctrl u_ctrl (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .strobe_o       (strobe_o),
    .mul_from_acc_o (mul_from_acc),
    .coef_sel_o     (coef_sel),
    .add_mode_o     (add_mode),
    .m0_we_o        (m0_we),
    .m0_waddr_o     (m0_waddr),
    .m0_raddr_o     (m0_raddr),
    .m1_we_o        (m1_we),
    .y_load_o       (y_load)
  );

  fb_regfile #(.W(DATA_W), .DEPTH(ST_DEPTH)) u_state_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (m0_we),
    .waddr_i (m0_waddr),
    .wdata_i (acc_q),
    .raddr_i (m0_raddr),
    .rdata_o (st_rd)
  );

  fb_regfile #(.W(DATA_W), .DEPTH(PRD_DEPTH)) u_prod_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (m1_we),
    .waddr_i (1'b0),
    .wdata_i (mul_q),
    .raddr_i (1'b0),
    .rdata_o (prd_rd)
  );

  always_comb begin
    mul_a = mul_from_acc ? acc_q : st_rd;
    unique case (coef_sel)
      CF_A1:   mul_c = COEF_W'(COEF_A1);
      CF_A2:   mul_c = COEF_W'(COEF_A2);
      CF_B1:   mul_c = COEF_W'(COEF_B1);
      default: mul_c = COEF_W'(COEF_B2);
    endcase
  end

  fb_cmul #(.DATA_W(DATA_W), .COEF_W(COEF_W), .FRAC_W(FRAC_W)) u_cmul (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .a_i    (mul_a),
    .c_i    (mul_c),
    .p_o    (mul_q)
  );

  always_comb begin
    unique case (add_mode)
      ADD_PRD_MUL: begin add_a = prd_rd; add_b = mul_q;  end
      ADD_ST_ACC:  begin add_a = st_rd;  add_b = acc_q;  end
      ADD_MUL_PRD: begin add_a = mul_q;  add_b = prd_rd; end
      default:     begin add_a = x_i;    add_b = acc_q;  end
    endcase
  end

  fb_sat_add #(.DATA_W(DATA_W)) u_add (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .a_i    (add_a),
    .b_i    (add_b),
    .s_o    (acc_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     y_o <= '0;
    else if (y_load) y_o <= acc_q;
  end

endmodule

// File: rtl/folded_biquad_chk.sv
module folded_biquad_chk #(
  parameter int DATA_W = 16
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     strobe_i,
  input logic signed [DATA_W-1:0] y_i,
  input logic signed [DATA_W-1:0] mul_a_i,
  input logic signed [DATA_W-1:0] mul_q_i
);

  logic [1:0] gap_q;
  logic       seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      gap_q <= strobe_i ? 2'd0 : gap_q + 2'd1;
      if (strobe_i) seen_q <= 1'b1;
    end
  end

  function automatic logic [DATA_W:0] mag(input logic signed [DATA_W-1:0] v);
    return v[DATA_W-1] ? -(DATA_W+1)'(v) : (DATA_W+1)'(v);
  endfunction

  AST_STROBE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i |=> !strobe_i);                                               // R2
  AST_STROBE_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i == (seen_q ? (gap_q == 2'd3) : (gap_q == 2'd3)));             // R2
  AST_Y_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_i |-> $stable(y_i));                                           // R3
  AST_Y_COLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_q |-> y_i == '0);                                                // R1
  AST_MUL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mag(mul_q_i) <= mag($past(mul_a_i, 2)));                               // R5

endmodule

bind folded_biquad folded_biquad_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .strobe_i (strobe_o),
  .y_i      (y_o),
  .mul_a_i  (mul_a),
  .mul_q_i  (mul_q)
);

// File: tb/sim_folded_biquad.sv
`timescale 1ns/1ps
module sim_folded_biquad;

  logic               clk = 1'b0;
  logic               rst_ni = 1'b0;
  logic signed [15:0] x_i = '0;
  logic signed [15:0] y_o;
  logic               strobe_o;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int w1 = 0, w2 = 0, exp_y = 0, last_y = 0;
  logic [15:0] junk = 16'hACE1;

  always #2.5 clk = ~clk;

  folded_biquad u0 (.clk_i(clk), .rst_ni(rst_ni), .x_i(x_i), .y_o(y_o), .strobe_o(strobe_o));

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: act=%0d exp<=%0d cycles", cyc, 100000);
      summary();
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, expv);
    end
  endtask

  function automatic int sat16(input int v);
    return v > 32767 ? 32767 : (v < -32768 ? -32768 : v);
  endfunction

  function automatic int prod(input int v, input int c); // R5 rounding
    return sat16((v * c + 16384) >>> 15);
  endfunction

  task automatic model_reset();
    w1 = 0; w2 = 0; exp_y = 0; last_y = 0;
  endtask

  task automatic model_step(input int x); // R6, R7
    int a, w, c;
    a = sat16(prod(w1, 6554) + prod(w2, 13107));
    w = sat16(x + a);
    c = sat16(prod(w1, 9830) + prod(w2, 19661));
    exp_y = sat16(w + c);
    w2 = w1; w1 = w;
  endtask

  // at a falling edge: run quiet cycles with junk input, then check the strobe and feed x
  task automatic period(input int x, input string req);
    while (!strobe_o) begin
      chk(y_o == last_y, "R3", y_o, last_y);
      junk = {junk[14:0], junk[15] ^ junk[13] ^ junk[12] ^ junk[10]};
      x_i = junk; // R4: ignored off-strobe
      @(negedge clk);
    end
    chk(y_o == exp_y, req, y_o, exp_y);
    last_y = exp_y;
    x_i = 16'(x);
    model_step(x);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    x_i = 16'h7FFF;
    @(negedge clk); @(negedge clk);
    chk(y_o == 0, "R1 y in reset", y_o, 0);
    chk(strobe_o == 0, "R1 strobe in reset", strobe_o, 0);
    model_reset();
    rst_ni = 1'b1;
    for (int i = 1; i <= 3; i++) begin
      @(negedge clk);
      chk(strobe_o == (i == 3), "R1 first strobe", strobe_o, i == 3);
    end
    chk(y_o == 0, "R1 y at first strobe", y_o, 0);
  endtask

  task automatic test_impulse();
    period(1000, "R7 impulse");
    period(0, "R7 impulse");
    chk(y_o == 1000, "R7 impulse latency", y_o, 1000);
    for (int i = 0; i < 12; i++) period(0, "R6 impulse tail");
  endtask

  task automatic test_pattern();
    for (int i = 0; i < 40; i++) period((i * 7919) % 12000 - 6000, "R6 mixed");
    for (int i = 0; i < 20; i++) period((i % 2) ? 9000 : -9000, "R7 alternating");
  endtask

  task automatic test_sat(input int lvl, input string req);
    for (int i = 0; i < 24; i++) period(lvl, req);
    chk(y_o == sat16(lvl * 8), "R8 rail", y_o, sat16(lvl * 8));
  endtask

  task automatic test_midreset();
    for (int i = 0; i < 5; i++) period(20000 - i * 3000, "R9 before reset");
    do_reset();
    period(1000, "R9 after reset");
    period(0, "R9 after reset");
    chk(y_o == 1000, "R9 cold response", y_o, 1000);
    for (int i = 0; i < 6; i++) period(0, "R9 after reset");
  endtask

  initial begin
    do_reset();
    test_impulse();
    test_pattern();
    test_sat(32767, "R8 positive");
    test_sat(-32768, "R8 negative");
    test_midreset();
    summary();
  end

endmodule